// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It supports a small fixed-length instruction subset: register-to-register arithmetic and logic, immediate arithmetic, word loads and stores, two conditional branches, and three unconditional transfers. Arithmetic reads its operands only from registers. Memory is reached only through loads and stores whose address is a base register plus a signed offset.

The instruction store and the data store are small word arrays inside the core. While reset is held, the instruction store is filled through a simple write port. After reset is released, the program runs from byte address 0. Two combinational debug ports return any register and any data word, and the current program counter is always visible. An external model can use these three outputs to compare architectural state at any cycle.

Top module: `lsr_core`

## Requirements
- R1: When `rst` is high at a rising edge, the core sets the PC to 0 and clears all 32 registers and every data word. No register or data-store write takes effect during that edge.
- R2: Register 0 always reads as zero, and writes to it are discarded.
- R3: Register-format instructions use opcode 0 and shamt 0. The funct field selects the operation: add=0x20, sub=0x22, and=0x24, or=0x25, slt=0x2A. rs and rt are the sources and rd is the destination. add and sub wrap modulo 2^32. slt writes 1 if rs < rt as signed values, and 0 otherwise.
- R4: Immediate instructions use rs as source and rt as destination. addi=0x08 and slti=0x0A sign-extend the 16-bit immediate. andi=0x0C and ori=0x0D zero-extend it. lui=0x0F writes the immediate to bits 31:16 and zeros bits 15:0.
- R5: lw=0x23 and sw=0x2B address the byte rs + sign-extended offset, and access the data word at index address[bits above 1]. sw takes its data from rt and writes no register.
- R6: beq=0x04 branches when rs equals rt, and bne=0x05 branches when they differ. The target is PC+4 plus the sign-extended offset shifted left by 2.
- R7: j=0x02 and jal=0x03 jump to {PC+4 bits 31:28, 26-bit field, 2'b00}. jal also writes PC+4 into register 31.
- R8: jr (opcode 0, funct 0x08, shamt 0) sets the PC to the rs value with bits 1:0 cleared.
- R9: In all other cases the next PC is PC+4. Any unlisted opcode, unlisted funct, or nonzero shamt in register format acts as a no-op and writes no state.
- R10: While reset is held, a write with `imem_we` high stores `imem_wdata` at word index `imem_widx`. The core fetches the word at index PC[bits above 1].
- R11: `dbg_reg_val` and `dbg_mem_val` show the register and data word selected by `dbg_reg_sel` and `dbg_mem_sel` without clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_widx | input | 6 | Instruction store word index |
| imem_wdata | input | 32 | Instruction word to store |
| dbg_reg_sel | input | 5 | Register selected for debug read |
| dbg_reg_val | output | 32 | Value of the selected register |
| dbg_mem_sel | input | 6 | Data word index for debug read |
| dbg_mem_val | output | 32 | Value of the selected data word |
| pc_o | output | 32 | Current program counter |

## Verification
The core has no pipeline, so a wrong write-back shows on the register debug port one edge after the faulty instruction. It also spreads into every later result that reads that register. A wrong branch, jump or link decision changes `pc_o` on the very next edge. The test programs therefore end in a self-jump, which makes the final PC a direct record of the control flow taken. A wrong store address or wrong store data remains in the data store and shows up when all data words are read after the run.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_J    = 6'h02;
  localparam logic [5:0] OPC_JAL  = 6'h03;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_BNE  = 6'h05;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_SLTI = 6'h0A;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_LUI  = 6'h0F;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;

  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [4:0] LINK_REG = 5'd31;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_HIGH
  } alu_op_e;

  typedef struct packed {
    logic    wb_en;
    logic    dst_rd;
    logic    dst_link;
    logic    imm_zext;
    logic    use_imm;
    alu_op_e alu_op;
    logic    ld;
    logic    st;
    logic    br_eq;
    logic    br_ne;
    logic    jmp;
    logic    jmp_link;
    logic    jmp_reg;
  } ctrl_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] zext16(input logic [15:0] v);
    return {16'h0000, v};
  endfunction

  function automatic logic [31:0] branch_dest(input logic [31:0] pc_plus4,
                                              input logic [15:0] ofs);
    return pc_plus4 + {sext16(ofs)[29:0], 2'b00};
  endfunction

  function automatic logic [31:0] jump_dest(input logic [31:0] pc_plus4,
                                            input logic [25:0] field);
    return {pc_plus4[31:28], field, 2'b00};
  endfunction

  function automatic logic [31:0] alu_eval(input alu_op_e op,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
    logic [31:0] r;
    case (op)
      ALU_ADD:  r = a + b;
      ALU_SUB:  r = a - b;
      ALU_AND:  r = a & b;
      ALU_OR:   r = a | b;
      ALU_SLT:  r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      ALU_HIGH: r = {b[15:0], 16'h0000};
      default:  r = a + b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
  import lsr_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic       shamt_zero;

  assign opc        = instr[31:26];
  assign fn         = instr[5:0];
  assign shamt_zero = (instr[10:6] == 5'd0);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    case (opc)
      OPC_REG: begin
        if (shamt_zero) begin
          case (fn)
            FN_ADD: begin ctrl.wb_en = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_ADD; end
            FN_SUB: begin ctrl.wb_en = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_SUB; end
            FN_AND: begin ctrl.wb_en = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_AND; end
            FN_OR:  begin ctrl.wb_en = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_OR;  end
            FN_SLT: begin ctrl.wb_en = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_SLT; end
            FN_JR:  ctrl.jmp_reg = 1'b1;
            default: ;
          endcase
        end
      end
      OPC_ADDI: begin ctrl.wb_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_ADD; end
      OPC_SLTI: begin ctrl.wb_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SLT; end
      OPC_ANDI: begin
        ctrl.wb_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.alu_op = ALU_AND;
      end
      OPC_ORI: begin
        ctrl.wb_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1; ctrl.alu_op = ALU_OR;
      end
      OPC_LUI:  begin ctrl.wb_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_HIGH; end
      OPC_LW:   begin ctrl.wb_en = 1'b1; ctrl.use_imm = 1'b1; ctrl.ld = 1'b1; end
      OPC_SW:   begin ctrl.use_imm = 1'b1; ctrl.st = 1'b1; end
      OPC_BEQ:  begin ctrl.br_eq = 1'b1; ctrl.alu_op = ALU_SUB; end
      OPC_BNE:  begin ctrl.br_ne = 1'b1; ctrl.alu_op = ALU_SUB; end
      OPC_J:    ctrl.jmp = 1'b1;
      OPC_JAL:  begin ctrl.jmp_link = 1'b1; ctrl.wb_en = 1'b1; ctrl.dst_link = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/lsr_alu.sv
module lsr_alu
  import lsr_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         is_zero
);
  always_comb begin
    y       = alu_eval(op, a, b);
    is_zero = (y == '0);
  end
endmodule

// File: rtl/lsr_regfile.sv
module lsr_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b,
  input  logic [AW-1:0] ra_dbg,
  output logic [W-1:0]  rd_dbg
);
  logic [W-1:0] regs [1:NREG-1];

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && waddr == AW'(g))
        regs[g] <= wdata;
    end
  end

  function automatic logic [W-1:0] rd_port(input logic [AW-1:0] a);
    return (a == '0) ? '0 : regs[a];
  endfunction

  always_comb begin
    rd_a   = rd_port(ra_a);
    rd_b   = rd_port(ra_b);
    rd_dbg = rd_port(ra_dbg);
  end
endmodule

// File: rtl/lsr_dmem.sv
module lsr_dmem #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [IW-1:0] dbg_idx,
  output logic [W-1:0]  dbg_data
);
  logic [W-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        mem[g] <= '0;
      else if (we && idx == IW'(g))
        mem[g] <= wdata;
    end
  end

  assign rdata    = mem[idx];
  assign dbg_data = mem[dbg_idx];
endmodule

// File: rtl/lsr_core.sv
module lsr_core
  import lsr_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA_W = $clog2(IMEM_WORDS),
  localparam int DA_W = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imem_we,
  input  logic [IA_W-1:0] imem_widx,
  input  logic [31:0]     imem_wdata,
  input  logic [4:0]      dbg_reg_sel,
  output logic [31:0]     dbg_reg_val,
  input  logic [DA_W-1:0] dbg_mem_sel,
  output logic [31:0]     dbg_mem_val,
  output logic [31:0]     pc_o
);
  logic [31:0] pc_q;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] instr;
  ctrl_t       ctrl;

  logic [4:0]  f_rs, f_rt, f_rd;
  logic [15:0] f_imm;
  logic [25:0] f_tgt;

  logic [31:0] rs_val, rt_val, imm_val, alu_b, alu_y, ld_val;
  logic        alu_zero;
  logic [31:0] pc_plus4, pc_next;

  // named events for the checker
  logic        reg_we;
  logic [4:0]  reg_waddr;
  logic [31:0] reg_wdata;
  logic        mem_we;
  logic        branch_taken;
  logic        is_jump;
  logic        jal_fire;

  always_ff @(posedge clk) begin
    if (rst && imem_we) imem[imem_widx] <= imem_wdata;
  end

  assign instr = imem[pc_q[IA_W+1:2]];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];
  assign f_tgt = instr[25:0];

  lsr_decode u_dec (.instr(instr), .ctrl(ctrl));

  lsr_regfile #(.NREG(32), .W(32)) u_rf (
    .clk(clk), .rst(rst),
    .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .ra_a(f_rs), .rd_a(rs_val),
    .ra_b(f_rt), .rd_b(rt_val),
    .ra_dbg(dbg_reg_sel), .rd_dbg(dbg_reg_val)
  );

  assign imm_val = ctrl.imm_zext ? zext16(f_imm) : sext16(f_imm);
  assign alu_b   = ctrl.use_imm ? imm_val : rt_val;

  lsr_alu #(.W(32)) u_alu (
    .op(ctrl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .is_zero(alu_zero)
  );

  lsr_dmem #(.WORDS(DMEM_WORDS), .W(32)) u_dm (
    .clk(clk), .rst(rst),
    .we(mem_we), .idx(alu_y[DA_W+1:2]), .wdata(rt_val), .rdata(ld_val),
    .dbg_idx(dbg_mem_sel), .dbg_data(dbg_mem_val)
  );

  assign pc_plus4 = pc_q + 32'd4;

  always_comb begin
    if (ctrl.dst_link)    reg_waddr = LINK_REG;
    else if (ctrl.dst_rd) reg_waddr = f_rd;
    else                  reg_waddr = f_rt;
    if (ctrl.jmp_link)    reg_wdata = pc_plus4;
    else if (ctrl.ld)     reg_wdata = ld_val;
    else                  reg_wdata = alu_y;
  end

  assign reg_we       = ctrl.wb_en & ~rst;
  assign mem_we       = ctrl.st & ~rst;
  assign branch_taken = (ctrl.br_eq & alu_zero) | (ctrl.br_ne & ~alu_zero);
  assign is_jump      = ctrl.jmp | ctrl.jmp_link | ctrl.jmp_reg;
  assign jal_fire     = ctrl.jmp_link;

  always_comb begin
    if (ctrl.jmp_reg)                   pc_next = {rs_val[31:2], 2'b00};
    else if (ctrl.jmp | ctrl.jmp_link)  pc_next = jump_dest(pc_plus4, f_tgt);
    else if (branch_taken)              pc_next = branch_dest(pc_plus4, f_imm);
    else                                pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/lsr_core_chk.sv
module lsr_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc_o,
  input logic        reg_we,
  input logic [4:0]  reg_waddr,
  input logic [31:0] reg_wdata,
  input logic        mem_we,
  input logic        branch_taken,
  input logic        is_jump,
  input logic        jal_fire,
  input logic [4:0]  dbg_reg_sel,
  input logic [31:0] dbg_reg_val
);
  assert_pc_cleared_R1: assert property (@(posedge clk)
    rst |=> (pc_o == 32'd0));

  assert_zero_reg_R2: assert property (@(posedge clk) disable iff (rst)
    (dbg_reg_sel == 5'd0) |-> (dbg_reg_val == 32'd0));

  assert_store_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !reg_we);

  assert_link_write_R7: assert property (@(posedge clk) disable iff (rst)
    jal_fire |-> (reg_we && reg_waddr == 5'd31 && reg_wdata == pc_o + 32'd4));

  assert_pc_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00);

  assert_seq_pc_R9: assert property (@(posedge clk) disable iff (rst)
    !(is_jump || branch_taken) |=> (pc_o == $past(pc_o) + 32'd4));
endmodule

bind lsr_core lsr_core_chk u_chk (
  .clk(clk), .rst(rst), .pc_o(pc_o),
  .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
  .mem_we(mem_we), .branch_taken(branch_taken), .is_jump(is_jump),
  .jal_fire(jal_fire), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val)
);

// File: tb/tb_lsr_core.sv
`timescale 1ns/1ps
module tb_lsr_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_widx = '0;
  logic [31:0] imem_wdata = '0;
  logic [4:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg_val;
  logic [5:0]  dbg_mem_sel = '0;
  logic [31:0] dbg_mem_val;
  logic [31:0] pc_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] prog [32];
  int plen = 0;

  always #2.5 clk = ~clk;

  lsr_core dut (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_widx(imem_widx),
    .imem_wdata(imem_wdata), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .dbg_mem_sel(dbg_mem_sel), .dbg_mem_val(dbg_mem_val), .pc_o(pc_o)
  );

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input int word_idx);
    return {op, 26'(word_idx)};
  endfunction

  task automatic put(input logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  task automatic put_halt();
    put(enc_j(6'h02, plen));
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic reg_is(input string req, input int idx, input logic [31:0] exp);
    dbg_reg_sel = 5'(idx);
    #0.5;
    check(req, $sformatf("r%0d", idx), dbg_reg_val, exp);
  endtask

  task automatic mem_is(input string req, input int idx, input logic [31:0] exp);
    dbg_mem_sel = 6'(idx);
    #0.5;
    check(req, $sformatf("mem[%0d]", idx), dbg_mem_val, exp);
  endtask

  // R10: program loaded while reset is held, then run
  task automatic load_and_run(input int cycles);
    @(posedge clk); #1;
    rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      imem_we = 1'b1; imem_widx = 6'(i);
      imem_wdata = (i < plen) ? prog[i] : 32'h0000_0000;
      @(posedge clk); #1;
    end
    imem_we = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (cycles) @(posedge clk);
    #1;
    plen = 0;
  endtask

  task automatic t_arith();
    put(enc_i(6'h0F, 0, 1, 16'h1234));          // lui r1
    put(enc_i(6'h0D, 1, 1, 16'h5678));          // ori r1
    put(enc_i(6'h08, 0, 2, 16'hFFFB));          // addi r2,-5
    put(enc_i(6'h08, 0, 3, 16'h0007));          // addi r3,7
    put(enc_r(2, 3, 4, 6'h20));                 // add
    put(enc_r(3, 2, 5, 6'h22));                 // sub
    put(enc_r(2, 3, 6, 6'h24));                 // and
    put(enc_r(2, 3, 7, 6'h25));                 // or
    put(enc_r(2, 3, 8, 6'h2A));                 // slt -5<7
    put(enc_r(3, 2, 9, 6'h2A));                 // slt 7<-5
    put(enc_i(6'h0A, 2, 10, 16'hFFFC));         // slti -5<-4
    put(enc_i(6'h0C, 2, 11, 16'hFFFF));         // andi zero-ext
    put(enc_i(6'h0F, 0, 12, 16'h7FFF));
    put(enc_i(6'h0D, 12, 12, 16'hFFFF));
    put(enc_i(6'h08, 12, 13, 16'h0001));        // wrap
    put(enc_i(6'h08, 0, 0, 16'h0005));          // write r0
    put(enc_i(6'h3F, 0, 15, 16'h1234));         // unknown opcode
    put(enc_r(2, 3, 16, 6'h3E));                // unknown funct
    put({6'h00, 5'd2, 5'd3, 5'd17, 5'd3, 6'h20}); // add with shamt!=0
    put_halt();                                  // index 19
    load_and_run(40);
    reg_is("R4", 1, 32'h1234_5678);
    reg_is("R4", 2, 32'hFFFF_FFFB);
    reg_is("R3", 4, 32'h0000_0002);
    reg_is("R3", 5, 32'h0000_000C);
    reg_is("R3", 6, 32'h0000_0003);
    reg_is("R3", 7, 32'hFFFF_FFFF);
    reg_is("R3", 8, 32'h0000_0001);
    reg_is("R3", 9, 32'h0000_0000);
    reg_is("R4", 10, 32'h0000_0001);
    reg_is("R4", 11, 32'h0000_FFFB);
    reg_is("R3", 13, 32'h8000_0000);
    reg_is("R2", 0, 32'h0000_0000);
    reg_is("R9", 15, 32'h0000_0000);
    reg_is("R9", 16, 32'h0000_0000);
    reg_is("R9", 17, 32'h0000_0000);
    check("R9", "pc at halt", pc_o, 32'd76);
  endtask

  task automatic t_memory();
    put(enc_i(6'h08, 0, 1, 16'd8));
    put(enc_i(6'h08, 0, 2, 16'h0055));
    put(enc_i(6'h2B, 1, 2, 16'd4));             // sw r2 -> byte 12
    put(enc_i(6'h23, 1, 3, 16'd4));             // lw r3
    put(enc_i(6'h08, 0, 4, 16'd20));
    put(enc_i(6'h2B, 4, 1, 16'hFFFC));          // sw r1 -> byte 16
    put(enc_i(6'h23, 4, 5, 16'hFFFC));          // lw r5
    put_halt();
    load_and_run(20);
    mem_is("R5", 3, 32'h0000_0055);
    mem_is("R5", 4, 32'h0000_0008);
    mem_is("R5", 2, 32'h0000_0000);
    reg_is("R5", 3, 32'h0000_0055);
    reg_is("R5", 5, 32'h0000_0008);
    reg_is("R5", 2, 32'h0000_0055);
  endtask

  task automatic t_reset();
    put_halt();
    load_and_run(0);
    check("R1", "pc after reset", pc_o, 32'd0);
    reg_is("R1", 3, 32'h0);
    mem_is("R1", 3, 32'h0);
    mem_is("R11", 4, 32'h0);
  endtask

  task automatic t_branch();
    put(enc_i(6'h08, 0, 1, 16'd3));             // 0
    put(enc_i(6'h08, 0, 2, 16'd3));             // 4
    put(enc_i(6'h04, 1, 2, 16'd2));             // 8 beq -> 20
    put(enc_i(6'h08, 0, 3, 16'd1));             // 12 skipped
    put(enc_i(6'h08, 0, 3, 16'd2));             // 16 skipped
    put(enc_i(6'h05, 1, 2, 16'd1));             // 20 bne not taken
    put(enc_i(6'h08, 0, 4, 16'd9));             // 24
    put(enc_i(6'h05, 1, 0, 16'd1));             // 28 bne -> 36
    put(enc_i(6'h08, 0, 5, 16'd1));             // 32 skipped
    put(enc_i(6'h08, 0, 6, 16'd7));             // 36
    put(enc_i(6'h08, 7, 7, 16'd1));             // 40
    put(enc_i(6'h05, 7, 1, 16'hFFFE));          // 44 back to 40
    put(enc_i(6'h08, 0, 8, 16'd1));             // 48
    put_halt();                                  // 52
    load_and_run(40);
    reg_is("R6", 3, 32'd0);
    reg_is("R6", 4, 32'd9);
    reg_is("R6", 5, 32'd0);
    reg_is("R6", 6, 32'd7);
    reg_is("R6", 7, 32'd3);
    reg_is("R6", 8, 32'd1);
    check("R6", "pc at halt", pc_o, 32'd52);
  endtask

  task automatic t_jump();
    put(enc_j(6'h03, 4));                       // 0 jal -> 16
    put(enc_i(6'h08, 0, 2, 16'd11));            // 4
    put(enc_j(6'h02, 6));                       // 8 j -> 24
    put(enc_i(6'h08, 0, 3, 16'd1));             // 12 skipped
    put(enc_i(6'h08, 0, 1, 16'd5));             // 16
    put(enc_r(31, 0, 0, 6'h08));                // 20 jr r31
    put(enc_i(6'h08, 0, 4, 16'h0023));          // 24
    put(enc_i(6'h08, 0, 5, 16'd43));            // 28
    put(enc_r(5, 0, 0, 6'h08));                 // 32 jr r5 -> 40
    put(enc_i(6'h08, 0, 6, 16'd1));             // 36 skipped
    put(enc_i(6'h08, 0, 7, 16'd4));             // 40
    put_halt();                                  // 44
    load_and_run(30);
    reg_is("R7", 31, 32'd4);
    reg_is("R7", 1, 32'd5);
    reg_is("R8", 2, 32'd11);
    reg_is("R7", 3, 32'd0);
    reg_is("R7", 4, 32'h23);
    reg_is("R8", 6, 32'd0);
    reg_is("R8", 7, 32'd4);
    check("R8", "pc at halt", pc_o, 32'd44);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_arith();
    t_memory();
    t_reset();
    t_branch();
    t_jump();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule